// File: doc/BRIEF.md
# Raster Timing Generator with Lagged Display Enable

This block produces the raster timing for a video subsystem. A horizontal counter steps through each line in half-cycle ticks and a vertical counter steps through the lines of a field. From these counters the block derives horizontal sync, vertical sync and a display-enable strobe. The display-enable strobe is high only where the horizontal active window and the vertical active window overlap.

The field rate sets the vertical active window, the number of lines in a field and the line length. The rate can be 50, 60 or 72 Hz. A small configuration port carries a 2-bit pixel-depth mode and a rate select. The block turns these into a pixel-depth code for the pixel path. Both one-bit-per-pixel modes force the 72 Hz timing.

Logic further along, such as an interrupt controller, does not see the enable strobe at once. A second enable output repeats every rising and falling transition of the strobe a fixed number of ticks later, 56 by default. Each transition is held in a small ordered queue, so transitions closer together than the delay are replayed in order, each at its own due tick.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is low and the pixel-depth code is 0. Pending delayed transitions are discarded.
- R2: `de_raw` is registered. After each clock edge it equals (H_EN_SET <= x < H_EN_RST) AND the vertical window for the line, both taken from the counter values before that edge.
- R3: `de_out` after edge k equals `de_raw` after edge k-DE_DELAY, with DE_DELAY = 56 by default. This holds for every transition, including transitions less than DE_DELAY apart.
- R4: The delay queue holds Q_DEPTH (4 by default) pending transitions and never overflows.
- R5: At 50 Hz (rate select 0, mode 0 or 1) a field has 313 lines, the vertical window covers lines 63 to 262, and a line has LINE_LEN_50 ticks.
- R6: At 60 Hz (rate select 1, mode 0 or 1) a field has 262 lines, the vertical window covers lines 34 to 233, and a line has LINE_LEN_60 ticks.
- R7: At 72 Hz a field has 500 lines, the vertical window covers lines 1 to 400, and a line has LINE_LEN_72 ticks.
- R8: `hsync` is high for line positions from line length minus 100 up to, but not including, line length minus 20.
- R9: `vsync` changes only at line position 60. At that point it takes the value (line < 3).
- R10: A write of mode 0 gives pixel-depth code 0 (4 bits per pixel). Mode 1 gives code 1 (2 bits). Modes 2 and 3 give code 2 (1 bit) and select 72 Hz whatever the rate select holds. The code is visible after the write edge, and the new timing applies from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one half-cycle tick per edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Pixel-depth mode written on cfg_we |
| cfg_rate_60 | input | 1 | Rate select written on cfg_we: 0 = 50 Hz, 1 = 60 Hz |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de_raw | output | 1 | Undelayed display enable |
| de_out | output | 1 | Display enable lagged by DE_DELAY ticks |
| bpp | output | 2 | Pixel-depth code: 0 = 4, 1 = 2, 2 = 1 bit per pixel |

## Verification
The overflow assertion relies on enable transitions being spaced so that no more than Q_DEPTH of them fall inside one delay window. That spacing depends on the horizontal window parameters, not on the input stimulus. The bench sets the window to 10 ticks, which puts two transitions inside each 56-tick window. Configuration writes may arrive at any tick, including mid-line and mid-field. The counters are assumed to recover from a field that shortens under them, so the random phase writes arbitrary modes at random points. The directed phases run complete fields at each rate.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [1:0] {RATE_50 = 2'd0, RATE_60 = 2'd1, RATE_72 = 2'd2} rate_e;
  typedef enum logic [1:0] {DEPTH4 = 2'd0, DEPTH2 = 2'd1, DEPTH1 = 2'd2} depth_e;

  localparam int unsigned HS_LEAD  = 100;
  localparam int unsigned HS_TAIL  = 20;
  localparam int unsigned VS_XPOS  = 60;
  localparam int unsigned VS_LINES = 3;

  function automatic int unsigned win_first(rate_e r);
    case (r)
      RATE_60: return 34;
      RATE_72: return 1;
      default: return 63;
    endcase
  endfunction

  function automatic int unsigned win_last_excl(rate_e r);
    case (r)
      RATE_60: return 234;
      RATE_72: return 401;
      default: return 263;
    endcase
  endfunction

  function automatic int unsigned field_lines(rate_e r);
    case (r)
      RATE_60: return 262;
      RATE_72: return 500;
      default: return 313;
    endcase
  endfunction
endpackage

// File: rtl/raster_mode_reg.sv
module raster_mode_reg
  import raster_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] mode,
  input  logic       rate_60,
  output rate_e      rate,
  output logic [1:0] depth
);
  rate_e      rate_q;
  logic [1:0] depth_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= RATE_50;
      depth_q <= DEPTH4;
    end else if (we) begin
      if (mode[1]) begin
        rate_q  <= RATE_72;
        depth_q <= DEPTH1;
      end else begin
        rate_q  <= rate_60 ? RATE_60 : RATE_50;
        depth_q <= mode[0] ? DEPTH2 : DEPTH4;
      end
    end
  end

  assign rate  = rate_q;
  assign depth = depth_q;

  AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
    depth_q != 2'd3); // R10
  AST_ONEBIT_FORCES_72: assert property (@(posedge clk) disable iff (rst)
    (depth_q == DEPTH1) |-> (rate_q == RATE_72)); // R10
endmodule

// File: rtl/raster_counters.sv
module raster_counters
  import raster_pkg::*;
#(
  parameter int unsigned XW          = 11,
  parameter int unsigned YW          = 9,
  parameter int unsigned LINE_LEN_50 = 1024,
  parameter int unsigned LINE_LEN_60 = 1024,
  parameter int unsigned LINE_LEN_72 = 1024,
  parameter int unsigned H_EN_SET    = 112,
  parameter int unsigned H_EN_RST    = 752
)(
  input  logic  clk,
  input  logic  rst,
  input  rate_e rate,
  output logic  hsync,
  output logic  vsync,
  output logic  de
);
  logic [XW-1:0] x_q, len_c, hs_on_c, hs_off_c;
  logic [YW-1:0] y_q, v_first_c, v_last_c, v_total_c;
  logic          hs_q, vs_q, de_q, hwin_c, vwin_c, eol_c;

  always_comb begin
    case (rate)
      RATE_60: len_c = XW'(LINE_LEN_60);
      RATE_72: len_c = XW'(LINE_LEN_72);
      default: len_c = XW'(LINE_LEN_50);
    endcase
    hs_on_c   = len_c - XW'(HS_LEAD);
    hs_off_c  = len_c - XW'(HS_TAIL);
    v_first_c = YW'(win_first(rate));
    v_last_c  = YW'(win_last_excl(rate));
    v_total_c = YW'(field_lines(rate));
    hwin_c    = (x_q >= XW'(H_EN_SET)) && (x_q < XW'(H_EN_RST));
    vwin_c    = (y_q >= v_first_c) && (y_q < v_last_c);
    eol_c     = (x_q >= len_c - XW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q  <= '0;
      y_q  <= '0;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
    end else begin
      hs_q <= (x_q >= hs_on_c) && (x_q < hs_off_c);
      de_q <= hwin_c && vwin_c;
      if (x_q == XW'(VS_XPOS)) vs_q <= (y_q < YW'(VS_LINES));
      if (eol_c) begin
        x_q <= '0;
        y_q <= (y_q >= v_total_c - YW'(1)) ? '0 : y_q + YW'(1);
      end else begin
        x_q <= x_q + XW'(1);
      end
    end
  end

  assign hsync = hs_q;
  assign vsync = vs_q;
  assign de    = de_q;

  AST_VSYNC_AT_XPOS: assert property (@(posedge clk) disable iff (rst)
    !$stable(vs_q) |-> ($past(x_q) == XW'(VS_XPOS))); // R9
  AST_LINE_STEP_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(y_q) |-> (x_q == '0)); // R5
endmodule

// File: rtl/de_delay_queue.sv
module de_delay_queue #(
  parameter int unsigned DELAY = 56,
  parameter int unsigned DEPTH = 4
)(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (DELAY == 0) begin : g_pass
      assign dout = din;
    end else if (DELAY == 1) begin : g_reg
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= din;
      end
      assign dout = q;
    end else begin : g_queue
      localparam int unsigned TW = $clog2(DELAY) + 1;
      localparam int unsigned AW = $clog2(DEPTH);

      logic [TW-1:0] tick_q;
      logic [TW-1:0] due_mem [DEPTH];
      logic          lvl_mem [DEPTH];
      logic [AW-1:0] wr_q, rd_q;
      logic [AW:0]   used_q;
      logic          prev_q, out_q, push_c, pop_c, full_c, push_ok_c;

      always_comb begin
        full_c    = (used_q == (AW+1)'(DEPTH));
        push_c    = (din != prev_q);
        push_ok_c = push_c && !full_c;
        pop_c     = (used_q != '0) && (due_mem[rd_q] == tick_q);
      end

      always_ff @(posedge clk) begin
        if (push_ok_c) begin
          due_mem[wr_q] <= tick_q + TW'(DELAY - 1);
          lvl_mem[wr_q] <= din;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          tick_q <= '0;
          wr_q   <= '0;
          rd_q   <= '0;
          used_q <= '0;
          prev_q <= 1'b0;
          out_q  <= 1'b0;
        end else begin
          tick_q <= tick_q + TW'(1);
          prev_q <= din;
          if (push_ok_c) wr_q <= wr_q + AW'(1);
          if (pop_c) begin
            out_q <= lvl_mem[rd_q];
            rd_q  <= rd_q + AW'(1);
          end
          case ({push_ok_c, pop_c})
            2'b10:   used_q <= used_q + (AW+1)'(1);
            2'b01:   used_q <= used_q - (AW+1)'(1);
            default: used_q <= used_q;
          endcase
        end
      end

      assign dout = out_q;

      AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(push_c && full_c)); // R4
      AST_OUT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_q) |-> $past(used_q != '0)); // R3
    end
  endgenerate
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned XW          = 11,
  parameter int unsigned YW          = 9,
  parameter int unsigned LINE_LEN_50 = 1024,
  parameter int unsigned LINE_LEN_60 = 1024,
  parameter int unsigned LINE_LEN_72 = 1024,
  parameter int unsigned H_EN_SET    = 112,
  parameter int unsigned H_EN_RST    = 752,
  parameter int unsigned DE_DELAY    = 56,
  parameter int unsigned Q_DEPTH     = 4
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_rate_60,
  output logic       hsync,
  output logic       vsync,
  output logic       de_raw,
  output logic       de_out,
  output logic [1:0] bpp
);
  rate_e rate_w;

  raster_mode_reg u_mode (
    .clk(clk), .rst(rst), .we(cfg_we), .mode(cfg_mode),
    .rate_60(cfg_rate_60), .rate(rate_w), .depth(bpp)
  );

  raster_counters #(
    .XW(XW), .YW(YW),
    .LINE_LEN_50(LINE_LEN_50), .LINE_LEN_60(LINE_LEN_60), .LINE_LEN_72(LINE_LEN_72),
    .H_EN_SET(H_EN_SET), .H_EN_RST(H_EN_RST)
  ) u_cnt (
    .clk(clk), .rst(rst), .rate(rate_w),
    .hsync(hsync), .vsync(vsync), .de(de_raw)
  );

  de_delay_queue #(.DELAY(DE_DELAY), .DEPTH(Q_DEPTH)) u_dly (
    .clk(clk), .rst(rst), .din(de_raw), .dout(de_out)
  );
endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
  localparam int L50 = 128, L60 = 120, L72 = 112, HS = 20, HR = 30, DLY = 56;

  logic clk = 0, rst = 1, cfg_we = 0, cfg_rate_60 = 0;
  logic [1:0] cfg_mode = 0;
  logic hsync, vsync, de_raw, de_out;
  logic [1:0] bpp;

  always #5 clk = ~clk;

  raster_timing_gen #(
    .LINE_LEN_50(L50), .LINE_LEN_60(L60), .LINE_LEN_72(L72),
    .H_EN_SET(HS), .H_EN_RST(HR), .DE_DELAY(DLY), .Q_DEPTH(4)
  ) u_raster_timing_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_rate_60(cfg_rate_60), .hsync(hsync), .vsync(vsync),
    .de_raw(de_raw), .de_out(de_out), .bpp(bpp)
  );

  int total = 0, fails = 0;
  bit done = 0, checking = 0;
  int mx, my, mrate;
  logic ehs, evs, ede;
  logic [1:0] ebpp;
  logic [63:0] hist;
  int vs_rises, dly_highs;
  logic vs_prev;

  function automatic int len_of(int r);
    return (r == 1) ? L60 : (r == 2) ? L72 : L50;
  endfunction
  function automatic int vfirst(int r);
    return (r == 1) ? 34 : (r == 2) ? 1 : 63;
  endfunction
  function automatic int vlast(int r);
    return (r == 1) ? 234 : (r == 2) ? 401 : 263;
  endfunction
  function automatic int vtotal(int r);
    return (r == 1) ? 262 : (r == 2) ? 500 : 313;
  endfunction

  task automatic check(string req, logic act, logic exp_v);
    total++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s at %0t: got %0b expected %0b", req, $time, act, exp_v);
    end
  endtask

  // Reference model from the requirements
  always @(posedge clk) begin
    if (rst) begin
      mx <= 0; my <= 0; mrate <= 0;
      ehs <= 0; evs <= 0; ede <= 0; ebpp <= 0;
    end else begin
      ehs <= (mx >= len_of(mrate) - 100) && (mx < len_of(mrate) - 20);  // R8
      ede <= (mx >= HS) && (mx < HR) && (my >= vfirst(mrate)) && (my < vlast(mrate));  // R2
      if (mx == 60) evs <= (my < 3);  // R9
      if (mx >= len_of(mrate) - 1) begin
        mx <= 0;
        my <= (my >= vtotal(mrate) - 1) ? 0 : my + 1;
      end else mx <= mx + 1;
      if (cfg_we) begin  // R10
        mrate <= cfg_mode[1] ? 2 : (cfg_rate_60 ? 1 : 0);
        ebpp  <= cfg_mode[1] ? 2'd2 : (cfg_mode[0] ? 2'd1 : 2'd0);
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      hist = '0; vs_prev = 0;
    end else if (checking) begin
      check("R8 hsync", hsync, ehs);
      check("R9 vsync", vsync, evs);
      if (mrate == 2)      check("R7 de_raw", de_raw, ede);
      else if (mrate == 1) check("R6 de_raw", de_raw, ede);
      else                 check("R5 de_raw", de_raw, ede);
      check("R2 de_raw", de_raw, ede);
      check("R3 de_out", de_out, hist[DLY-1]);  // R4 via lossless replay
      check("R10 bpp[0]", bpp[0], ebpp[0]);
      check("R10 bpp[1]", bpp[1], ebpp[1]);
      if (vsync && !vs_prev) vs_rises++;
      if (de_out) dly_highs++;
      vs_prev = vsync;
      hist = {hist[62:0], de_raw};
    end
  end

  task automatic wr(logic [1:0] m, logic r);
    @(negedge clk);
    cfg_we = 1; cfg_mode = m; cfg_rate_60 = r;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic reset_check();
    @(negedge clk); rst = 1; checking = 0;
    repeat (3) @(negedge clk);
    check("R1 hsync", hsync, 0); check("R1 vsync", vsync, 0);
    check("R1 de_raw", de_raw, 0); check("R1 de_out", de_out, 0);
    check("R1 bpp", |bpp, 0);
    rst = 0;
    @(negedge clk);
    check("R1 de_out after", de_out, 0);
    checking = 1;
  endtask

  task automatic phase(string req, logic [1:0] m, logic r, int cycles);
    wr(m, r);
    vs_rises = 0; dly_highs = 0;
    repeat (cycles) @(negedge clk);
    total++;
    if (vs_rises == 0 || dly_highs == 0) begin
      fails++;
      $display("FAIL %s R9/R3 activity: vsync rises %0d de_out highs %0d expected nonzero",
               req, vs_rises, dly_highs);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(11);
    reset_check();
    phase("R5", 2'd0, 1'b0, 41000);
    phase("R6", 2'd1, 1'b1, 32500);
    phase("R7", 2'd3, 1'b0, 57000);
    for (int i = 0; i < 12; i++) begin
      wr(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(200, 2500)) @(negedge clk);
    end
    reset_check();
    repeat (200) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule